// File: doc/BRIEF.md
# Over-Temperature Alarm and Shutdown Controller

This block watches a stream of digitised die-temperature codes and compares each valid code against an over-temperature limit. The limit comes from a software register. Until software writes that register, the block uses a built-in default equal to the code for 125 °C. A code above the limit raises the alarm, and a code below the limit clears it. Each new alarm latches a sticky interrupt flag for the host processor. If shutdown was enabled when the block left reset, the block also drives a power-down request for the programmable-logic region. That request holds until the alarm clears or a reconfiguration request arrives.

Software reaches the block through a small synchronous register port with address, write strobe, write data, read data and a ready pulse. The port holds three registers:

- **Limit register** at address 0: the 12-bit limit.
- **Configuration register** at address 1: the alarm-disable bit plus two read-only flags.
- **Status register** at address 2: the sticky interrupt flag and the live alarm level.

The sensor, the converter, the power switches and the reconfiguration engine sit outside the block.

Top module: `otemp_guard`

## Requirements
- R1: After reset, `alarm`, `irq` and `pwr_down` are 0. The limit register (address 0, bits 11:0) reads the default code 0xCA4. The threshold-programmed flag (address 1, bit 2) reads 0. A later reset restores both the default limit and the cleared flag.
- R2: `alarm` goes to 1 on the cycle after a sample with `samp_valid`=1 and `samp_code` strictly greater than the active limit. Codes presented with `samp_valid`=0 have no effect.
- R3: `alarm` goes to 0 on the cycle after a valid sample strictly below the active limit. A valid sample equal to the limit leaves `alarm` unchanged.
- R4: A write to address 0 replaces the limit for every following sample. The write also sets the threshold-programmed flag (address 1, bit 2), which stays set until reset.
- R5: Configuration bit 0 is the alarm-disable bit. While it is 1, `alarm` is forced to 0 from the cycle after the write, so no interrupt or power-down can follow. Writing 0 re-enables the comparison, and `alarm` then follows the next valid sample.
- R6: Status bit 0, which is also the `irq` output, is set on the cycle after `alarm` rises and then holds. Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. A new rise wins over a clear in the same cycle. Status bit 1 reads the live alarm level.
- R7: `shdn_en_cfg` is sampled while `rst` is high and reads back as configuration bit 1. When it is 1, `pwr_down` goes to 1 on the cycle after `alarm` rises. When it is 0, `pwr_down` stays 0.
- R8: `pwr_down` drops on the cycle after `alarm` is 0 or `reconfig_req` is 1 while it is asserted. After a reconfiguration release it stays 0 until `alarm` rises again.
- R9: `reg_ready` pulses on the cycle after `reg_req`, and `reg_rdata` is valid in that cycle. Addresses 3 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_en_cfg | input | 1 | Shutdown enable, captured during reset |
| samp_valid | input | 1 | One-cycle strobe qualifying `samp_code` |
| samp_code | input | 12 | Unsigned temperature code |
| reconfig_req | input | 1 | Reconfiguration request; releases power-down |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_ready | output | 1 | Access completion, one cycle after request |
| reg_rdata | output | 12 | Read data, valid with `reg_ready` |
| alarm | output | 1 | Live over-temperature alarm |
| irq | output | 1 | Sticky interrupt flag toward the host |
| pwr_down | output | 1 | Power-down request for the logic region |

## Verification
The block's results fall due at fixed delays:

- `alarm` changes one clock after a valid sample.
- `irq` and `pwr_down` follow one clock after that.
- `pwr_down` releases one clock after its release condition.
- Register writes take effect, and read data appears with `reg_ready`, one clock after the request.

A behavioural reference model in the bench advances on every rising edge from the same inputs. It is compared with all outputs on the following falling edge, so each result is checked exactly in the cycle it falls due. Directed checks sample at those same falling edges after the stimulus tasks return. They cover the equal-code hold, ignored invalid codes, write-0 to the sticky flag, release by reconfiguration, the disabled alarm and unmapped addresses.

// File: rtl/otg_pkg.sv
package otg_pkg;
  // register address map
  localparam int unsigned OTG_ADDR_LIMIT  = 0;
  localparam int unsigned OTG_ADDR_CONFIG = 1;
  localparam int unsigned OTG_ADDR_STATUS = 2;

  // configuration register bit positions
  localparam int unsigned CFG_DIS_BIT  = 0;
  localparam int unsigned CFG_SHDN_BIT = 1;
  localparam int unsigned CFG_PROG_BIT = 2;

  // status register bit positions
  localparam int unsigned STS_IRQ_BIT   = 0;
  localparam int unsigned STS_ALARM_BIT = 1;
endpackage

// File: rtl/otg_compare.sv
module otg_compare #(
  parameter int unsigned TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_code,
  input  logic [TEMP_W-1:0] limit,
  input  logic              alarm_off,
  output logic              alarm,
  output logic              alarm_rise
);
  logic alarm_q;
  logic alarm_d;
  logic above;
  logic below;

  assign above = samp_code > limit;
  assign below = samp_code < limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
      alarm_d <= 1'b0;
    end else begin
      alarm_d <= alarm_q;
      if (alarm_off) begin
        alarm_q <= 1'b0;
      end else if (samp_valid) begin
        if (above) begin
          alarm_q <= 1'b1;
        end else if (below) begin
          alarm_q <= 1'b0;
        end
      end
    end
  end

  assign alarm      = alarm_q;
  assign alarm_rise = alarm_q & ~alarm_d;

  AST_ALARM_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> ($past(samp_valid) && ($past(samp_code) > $past(limit)))); // R2
  AST_ALARM_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_q) |-> ($past(alarm_off) || ($past(samp_valid) && ($past(samp_code) < $past(limit))))); // R3
  AST_ALARM_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    alarm_off |=> !alarm_q); // R5
endmodule

// File: rtl/otg_pwrseq.sv
module otg_pwrseq (
  input  logic clk,
  input  logic rst,
  input  logic shdn_cfg,
  input  logic alarm,
  input  logic alarm_rise,
  input  logic reconfig_req,
  output logic shdn_en,
  output logic pwr_down
);
  logic shdn_q;
  logic pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shdn_q <= shdn_cfg;
      pd_q   <= 1'b0;
    end else if (pd_q) begin
      if (!alarm || reconfig_req) begin
        pd_q <= 1'b0;
      end
    end else if (alarm_rise && shdn_q) begin
      pd_q <= 1'b1;
    end
  end

  assign shdn_en  = shdn_q;
  assign pwr_down = pd_q;

  AST_PD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    pd_q |-> shdn_q); // R7
  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (alarm_rise && shdn_q && !pd_q) |=> pd_q); // R7
  AST_PD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pd_q && (!alarm || reconfig_req)) |=> !pd_q); // R8
endmodule

// File: rtl/otg_regfile.sv
module otg_regfile #(
  parameter int unsigned              TEMP_W        = 12,
  parameter int unsigned              ADDR_W        = 4,
  parameter logic [TEMP_W-1:0]        DEFAULT_LIMIT = 12'hCA4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [TEMP_W-1:0] reg_wdata,
  output logic              reg_ready,
  output logic [TEMP_W-1:0] reg_rdata,
  input  logic              alarm,
  input  logic              alarm_rise,
  input  logic              shdn_en,
  output logic [TEMP_W-1:0] limit,
  output logic              alarm_off,
  output logic              irq
);
  import otg_pkg::*;

  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(OTG_ADDR_LIMIT);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OTG_ADDR_CONFIG);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OTG_ADDR_STATUS);

  logic [TEMP_W-1:0] lim_q;
  logic              prog_q;
  logic              dis_q;
  logic              irq_q;
  logic              ready_q;
  logic [TEMP_W-1:0] rdata_q;
  logic [TEMP_W-1:0] rd_mux;
  logic              wr_lim;
  logic              wr_cfg;
  logic              wr_sts;
  logic              irq_clr;

  assign wr_lim  = reg_req && reg_wr && (reg_addr == A_LIM);
  assign wr_cfg  = reg_req && reg_wr && (reg_addr == A_CFG);
  assign wr_sts  = reg_req && reg_wr && (reg_addr == A_STS);
  assign irq_clr = wr_sts && reg_wdata[STS_IRQ_BIT];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_LIM: rd_mux = lim_q;
      A_CFG: begin
        rd_mux[CFG_DIS_BIT]  = dis_q;
        rd_mux[CFG_SHDN_BIT] = shdn_en;
        rd_mux[CFG_PROG_BIT] = prog_q;
      end
      A_STS: begin
        rd_mux[STS_IRQ_BIT]   = irq_q;
        rd_mux[STS_ALARM_BIT] = alarm;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q   <= DEFAULT_LIMIT;
      prog_q  <= 1'b0;
      dis_q   <= 1'b0;
      irq_q   <= 1'b0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= reg_req;
      rdata_q <= reg_req ? rd_mux : '0;
      if (wr_lim) begin
        lim_q  <= reg_wdata;
        prog_q <= 1'b1;
      end
      if (wr_cfg) begin
        dis_q <= reg_wdata[CFG_DIS_BIT];
      end
      if (alarm_rise) begin
        irq_q <= 1'b1;
      end else if (irq_clr) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign reg_ready = ready_q;
  assign reg_rdata = rdata_q;
  assign limit     = lim_q;
  assign alarm_off = dis_q;
  assign irq       = irq_q;

  AST_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
    reg_req |=> reg_ready); // R9
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    alarm_rise |=> irq_q); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q); // R6
  AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    prog_q |=> prog_q); // R4
endmodule

// File: rtl/otemp_guard.sv
module otemp_guard #(
  parameter int unsigned       TEMP_W        = 12,
  parameter int unsigned       ADDR_W        = 4,
  parameter logic [TEMP_W-1:0] DEFAULT_LIMIT = 12'hCA4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn_en_cfg,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_code,
  input  logic              reconfig_req,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [TEMP_W-1:0] reg_wdata,
  output logic              reg_ready,
  output logic [TEMP_W-1:0] reg_rdata,
  output logic              alarm,
  output logic              irq,
  output logic              pwr_down
);
  logic [TEMP_W-1:0] limit;
  logic              alarm_off;
  logic              alarm_rise;
  logic              shdn_en;

  otg_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .samp_code  (samp_code),
    .limit      (limit),
    .alarm_off  (alarm_off),
    .alarm      (alarm),
    .alarm_rise (alarm_rise)
  );

  otg_pwrseq u_pwr (
    .clk          (clk),
    .rst          (rst),
    .shdn_cfg     (shdn_en_cfg),
    .alarm        (alarm),
    .alarm_rise   (alarm_rise),
    .reconfig_req (reconfig_req),
    .shdn_en      (shdn_en),
    .pwr_down     (pwr_down)
  );

  otg_regfile #(
    .TEMP_W        (TEMP_W),
    .ADDR_W        (ADDR_W),
    .DEFAULT_LIMIT (DEFAULT_LIMIT)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_ready  (reg_ready),
    .reg_rdata  (reg_rdata),
    .alarm      (alarm),
    .alarm_rise (alarm_rise),
    .shdn_en    (shdn_en),
    .limit      (limit),
    .alarm_off  (alarm_off),
    .irq        (irq)
  );
endmodule

// File: tb/tb_otemp_guard.sv
module tb_otemp_guard;
  localparam int TW = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          shdn_en_cfg = 1'b1;
  logic          samp_valid = 1'b0;
  logic [TW-1:0] samp_code = '0;
  logic          reconfig_req = 1'b0;
  logic          reg_req = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [TW-1:0] reg_wdata = '0;
  logic          reg_ready;
  logic [TW-1:0] reg_rdata;
  logic          alarm;
  logic          irq;
  logic          pwr_down;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  otemp_guard dut (
    .clk(clk), .rst(rst), .shdn_en_cfg(shdn_en_cfg),
    .samp_valid(samp_valid), .samp_code(samp_code), .reconfig_req(reconfig_req),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .alarm(alarm), .irq(irq), .pwr_down(pwr_down)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int m_lim, m_prog, m_dis, m_irq, m_alarm, m_alarm_d, m_pd, m_shdn, m_ready, m_rdata;

  always @(posedge clk) begin
    int n_alarm, n_irq, n_pd, rise, rd;
    if (rst) begin
      m_lim = 'hCA4; m_prog = 0; m_dis = 0; m_irq = 0; m_alarm = 0;
      m_alarm_d = 0; m_pd = 0; m_shdn = shdn_en_cfg; m_ready = 0; m_rdata = 0;
    end else begin
      rise = m_alarm && !m_alarm_d;
      n_alarm = m_alarm;
      if (m_dis) n_alarm = 0;
      else if (samp_valid) begin
        if (int'(samp_code) > m_lim) n_alarm = 1;
        else if (int'(samp_code) < m_lim) n_alarm = 0;
      end
      n_irq = m_irq;
      if (rise) n_irq = 1;
      else if (reg_req && reg_wr && reg_addr == 2 && reg_wdata[0]) n_irq = 0;
      n_pd = m_pd;
      if (m_pd) begin
        if (!m_alarm || reconfig_req) n_pd = 0;
      end else if (rise && m_shdn) n_pd = 1;
      rd = 0;
      if (reg_addr == 0) rd = m_lim;
      else if (reg_addr == 1) rd = m_dis + 2 * m_shdn + 4 * m_prog;
      else if (reg_addr == 2) rd = m_irq + 2 * m_alarm;
      m_ready = reg_req;
      m_rdata = reg_req ? rd : 0;
      if (reg_req && reg_wr && reg_addr == 0) begin m_lim = int'(reg_wdata); m_prog = 1; end
      if (reg_req && reg_wr && reg_addr == 1) m_dis = reg_wdata[0];
      m_alarm_d = m_alarm;
      m_alarm = n_alarm;
      m_irq = n_irq;
      m_pd = n_pd;
    end
    started = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 R3 model alarm", int'(alarm), m_alarm);
      chk("R6 model irq", int'(irq), m_irq);
      chk("R7 R8 model pwr_down", int'(pwr_down), m_pd);
      chk("R9 model reg_ready", int'(reg_ready), m_ready);
      chk("R9 model reg_rdata", int'(reg_rdata), m_rdata);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic cfg);
    rst = 1'b1; shdn_en_cfg = cfg;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic sample(input int code);
    samp_valid = 1'b1; samp_code = TW'(code);
    step();
    samp_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = TW'(d);
    step();
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = AW'(a);
    step();
    chk("R9 ready after request", int'(reg_ready), 1);
    d = int'(reg_rdata);
    reg_req = 1'b0;
  endtask

  initial begin
    int v;
    step();
    do_reset(1'b1);
    chk("R1 alarm after reset", int'(alarm), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 pwr_down after reset", int'(pwr_down), 0);
    rd(0, v); chk("R1 default limit", v, 'hCA4);
    rd(1, v); chk("R1 R7 config flags", v, 2);

    sample('hCA4); chk("R3 equal code holds low", int'(alarm), 0);
    sample('hCA5); chk("R2 alarm sets above limit", int'(alarm), 1);
    chk("R6 irq not yet", int'(irq), 0);
    step();
    chk("R6 irq after rise", int'(irq), 1);
    chk("R7 pwr_down after rise", int'(pwr_down), 1);
    samp_code = '0; step();
    chk("R2 invalid code ignored", int'(alarm), 1);
    sample('hCA4); chk("R3 equal code holds high", int'(alarm), 1);
    sample('hCA3); chk("R3 alarm clears below", int'(alarm), 0);
    chk("R8 pwr_down held one more cycle", int'(pwr_down), 1);
    step(); chk("R8 pwr_down released", int'(pwr_down), 0);

    rd(2, v); chk("R6 status sticky", v, 1);
    wr(2, 0); chk("R6 write 0 keeps irq", int'(irq), 1);
    wr(2, 1); chk("R6 write 1 clears irq", int'(irq), 0);

    wr(0, 'h800);
    rd(1, v); chk("R4 programmed flag", v, 6);
    sample('h801); chk("R4 new limit used", int'(alarm), 1);
    step(); chk("R7 pwr_down on new rise", int'(pwr_down), 1);
    reconfig_req = 1'b1; step(); reconfig_req = 1'b0;
    chk("R8 reconfig releases", int'(pwr_down), 0);
    step(); step();
    chk("R8 no re-entry while high", int'(pwr_down), 0);
    wr(2, 1);

    wr(1, 1); step();
    chk("R5 disable forces alarm low", int'(alarm), 0);
    sample('hFFF); step();
    chk("R5 disabled ignores hot code", int'(alarm), 0);
    chk("R5 disabled no irq", int'(irq), 0);
    chk("R5 disabled no pwr_down", int'(pwr_down), 0);
    wr(1, 0); step();
    chk("R5 re-enabled waits for sample", int'(alarm), 0);
    sample('h900); chk("R5 re-enabled alarm", int'(alarm), 1);
    rd(2, v); chk("R6 live alarm bit", (v >> 1) & 1, 1);

    rd(3, v); chk("R9 unmapped reads zero", v, 0);
    wr(3, 'hFFF);
    rd(0, v); chk("R9 unmapped write ignored", v, 'h800);

    do_reset(1'b0);
    rd(0, v); chk("R1 reset restores default", v, 'hCA4);
    rd(1, v); chk("R1 R7 flags after second reset", v, 0);
    sample('hFFF); chk("R2 alarm with shutdown off", int'(alarm), 1);
    step(); step();
    chk("R7 no pwr_down when disabled", int'(pwr_down), 0);
    chk("R6 irq still raised", int'(irq), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule